// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block turns a free-running pixel clock into the raster timing a TFT display expects. It emits a horizontal sync pulse, a vertical sync pulse and a data-enable strobe. It also gives the column and row of the current active pixel, so a downstream pixel-fetch unit knows which word to present. Software programs nine timing fields through a small write port. Those fields cover the horizontal and vertical active sizes, porches and sync widths, plus a delay that separates every vertical sync edge from the horizontal sync pulse that follows it.

Vertical timing is counted in whole lines and horizontal timing in pixel clocks. A frame runs in this order: the vertical sync lines, the back-porch idle lines, the active lines, then the front-porch idle lines. Each line has the same layout: the sync pulse, the back porch, the active pixels, then the front porch.

A mode input selects passive-matrix operation. In that mode the vertical porch, vertical pulse-width and delay fields count as zero. Fields written through the port are held in a staging copy, which the timing logic picks up only at a frame boundary.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is held, and after it with all fields zero, hsync_o and de_o are low and pix_x_o and line_y_o are zero.
- R2: The line period is HPW+1+HBP+HACT+HFP clocks, and every line carries one HSYNC pulse exactly HPW+1 clocks wide.
- R3: VSYNC rises in the first clock of a line and stays high for VPW+1 whole lines.
- R4: A frame lasts VPW+1+VBP+VACT+VFP lines. The first enabled pixel sits VBP lines after the end of VSYNC and HPW+1+HBP clocks into its line, and VFP idle lines follow the last enabled pixel's line.
- R5: On the line where VSYNC rises and on the line where it falls, HSYNC rises VDLY+1 clocks after that VSYNC edge.
- R6: de_o is high exactly for HACT pixels on each of VACT lines, never while VSYNC is high. While it is high, pix_x_o runs from 0 to HACT-1 and line_y_o from 0 to VACT-1.
- R7: With mode_stn high at a frame start, that frame uses VPW, VBP, VFP and VDLY as zero: VSYNC lasts one line, the frame has 1+VACT lines, and the delay is one clock.
- R8: A field write, and the mode input, take effect at the next frame start only. The frame in progress keeps its old timing.
- R9: Field addresses are 0 VFP, 1 VBP, 2 VPW, 3 VDLY, 4 HFP, 5 HBP, 6 HPW, 7 HACT, 8 VACT. A write to any address from 9 to 15 changes no timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_stn | input | 1 | Passive-matrix mode select, sampled at frame start |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 4 | Field address |
| wr_data | input | 10 | Field value |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable for active pixels |
| pix_x_o | output | 12 | Active column, zero outside the active region |
| line_y_o | output | 12 | Active row, zero outside the active region |

## Verification
The bench goes after the two delayed HSYNC lines: a design that kept HSYNC at the line start would show a gap of zero, and one that delayed only on the rising edge would miss the falling-edge gap. All-zero porch and pulse fields check that a zero width still gives a one-line VSYNC and a one-clock HSYNC. A design that decoded the raw field would instead lose the pulse or be off by one line in frame length. A field rewritten in the middle of a frame exposes a design that applies writes at once, because that frame would be cut short. In passive-matrix mode, any design that still honours the vertical fields gives a longer frame and a wider VSYNC.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    // Width of every programmable timing field
    parameter int unsigned LCD_FW = 10;
    // Counter width: holds the sum of four fields plus one
    localparam int unsigned LCD_CW = LCD_FW + 2;
    localparam int unsigned LCD_AW = 4;

    typedef enum logic [LCD_AW-1:0] {
        FLD_VFP  = 4'd0,
        FLD_VBP  = 4'd1,
        FLD_VPW  = 4'd2,
        FLD_VDLY = 4'd3,
        FLD_HFP  = 4'd4,
        FLD_HBP  = 4'd5,
        FLD_HPW  = 4'd6,
        FLD_HACT = 4'd7,
        FLD_VACT = 4'd8
    } fld_addr_e;

    typedef struct packed {
        logic              stn;
        logic [LCD_FW-1:0] vfp;
        logic [LCD_FW-1:0] vbp;
        logic [LCD_FW-1:0] vpw;
        logic [LCD_FW-1:0] vdly;
        logic [LCD_FW-1:0] hfp;
        logic [LCD_FW-1:0] hbp;
        logic [LCD_FW-1:0] hpw;
        logic [LCD_FW-1:0] hact;
        logic [LCD_FW-1:0] vact;
    } lcd_cfg_t;

endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LCD_AW-1:0] wr_addr,
    input  logic [LCD_FW-1:0] wr_data,
    input  logic              mode_stn,
    input  logic              load,
    output lcd_cfg_t          cfg_o
);

    typedef struct packed {
        lcd_cfg_t stage;
        lcd_cfg_t live;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                FLD_VFP:  r_d.stage.vfp  = wr_data;
                FLD_VBP:  r_d.stage.vbp  = wr_data;
                FLD_VPW:  r_d.stage.vpw  = wr_data;
                FLD_VDLY: r_d.stage.vdly = wr_data;
                FLD_HFP:  r_d.stage.hfp  = wr_data;
                FLD_HBP:  r_d.stage.hbp  = wr_data;
                FLD_HPW:  r_d.stage.hpw  = wr_data;
                FLD_HACT: r_d.stage.hact = wr_data;
                FLD_VACT: r_d.stage.vact = wr_data;
                default:  ;
            endcase
        end
        if (load) begin
            r_d.live     = r_q.stage;
            r_d.live.stn = mode_stn;
            if (mode_stn) begin
                r_d.live.vfp  = '0;
                r_d.live.vbp  = '0;
                r_d.live.vpw  = '0;
                r_d.live.vdly = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o = r_q.live;

    // R8: live timing only changes after a frame boundary
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(cfg_o))
        else $error("live timing changed mid-frame");

endmodule

// File: rtl/lcd_frame_cnt.sv
module lcd_frame_cnt
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lcd_cfg_t          cfg,
    output logic [LCD_CW-1:0] h_o,
    output logic [LCD_CW-1:0] v_o,
    output logic              line_start_o,
    output logic              frame_end_o
);

    typedef struct packed {
        logic [LCD_CW-1:0] h;
        logic [LCD_CW-1:0] v;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [LCD_CW-1:0] h_tot, v_tot;
    logic              line_end;

    always_comb begin
        h_tot    = LCD_CW'(cfg.hpw) + LCD_CW'(1) + LCD_CW'(cfg.hbp)
                 + LCD_CW'(cfg.hact) + LCD_CW'(cfg.hfp);
        v_tot    = LCD_CW'(cfg.vpw) + LCD_CW'(1) + LCD_CW'(cfg.vbp)
                 + LCD_CW'(cfg.vact) + LCD_CW'(cfg.vfp);
        line_end = (c_q.h == h_tot - LCD_CW'(1));
        c_d      = c_q;
        if (line_end) begin
            c_d.h = '0;
            c_d.v = (c_q.v == v_tot - LCD_CW'(1)) ? '0 : c_q.v + LCD_CW'(1);
        end else begin
            c_d.h = c_q.h + LCD_CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign h_o          = c_q.h;
    assign v_o          = c_q.v;
    assign line_start_o = (c_q.h == '0);
    assign frame_end_o  = line_end && (c_q.v == v_tot - LCD_CW'(1));

    // R2: pixel counter never leaves the programmed line
    p_h_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        h_o < h_tot)
        else $error("pixel counter beyond line length");

    // R4: line counter never leaves the programmed frame
    p_v_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v_o < v_tot)
        else $error("line counter beyond frame length");

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode
    import lcd_sync_pkg::*;
(
    input  lcd_cfg_t          cfg,
    input  logic [LCD_CW-1:0] h,
    input  logic [LCD_CW-1:0] v,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [LCD_CW-1:0] pix_x_o,
    output logic [LCD_CW-1:0] line_y_o
);

    logic [LCD_CW-1:0] vs_len, hs_beg, hs_len, x_beg, y_beg;
    logic              edge_line, in_x, in_y;

    always_comb begin
        vs_len    = LCD_CW'(cfg.vpw) + LCD_CW'(1);
        hs_len    = LCD_CW'(cfg.hpw) + LCD_CW'(1);
        edge_line = (v == '0) || (v == vs_len);
        hs_beg    = edge_line ? LCD_CW'(cfg.vdly) + LCD_CW'(1) : '0;
        x_beg     = hs_len + LCD_CW'(cfg.hbp);
        y_beg     = vs_len + LCD_CW'(cfg.vbp);
        in_x      = (h >= x_beg) && (h < x_beg + LCD_CW'(cfg.hact));
        in_y      = (v >= y_beg) && (v < y_beg + LCD_CW'(cfg.vact));
        vsync_o   = (v < vs_len);
        hsync_o   = (h >= hs_beg) && (h < hs_beg + hs_len);
        de_o      = in_x && in_y;
        pix_x_o   = de_o ? h - x_beg : '0;
        line_y_o  = de_o ? v - y_beg : '0;
    end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_stn,
    input  logic              wr_en,
    input  logic [LCD_AW-1:0] wr_addr,
    input  logic [LCD_FW-1:0] wr_data,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [LCD_CW-1:0] pix_x_o,
    output logic [LCD_CW-1:0] line_y_o
);

    lcd_cfg_t          cfg;
    logic [LCD_CW-1:0] h_cnt, v_cnt;
    logic              line_start, frame_end;

    lcd_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode_stn (mode_stn),
        .load     (frame_end),
        .cfg_o    (cfg)
    );

    lcd_frame_cnt u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (cfg),
        .h_o          (h_cnt),
        .v_o          (v_cnt),
        .line_start_o (line_start),
        .frame_end_o  (frame_end)
    );

    lcd_sync_decode u_dec (
        .cfg      (cfg),
        .h        (h_cnt),
        .v        (v_cnt),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .de_o     (de_o),
        .pix_x_o  (pix_x_o),
        .line_y_o (line_y_o)
    );

    // R3: vertical sync begins with a line
    p_vs_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> line_start)
        else $error("vsync rose mid-line");

    // R6: no enabled pixel inside the vertical sync
    p_de_vsync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> !vsync_o)
        else $error("data enable during vsync");

    // R6: active column stays below the active width
    p_pix_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (pix_x_o < LCD_CW'(cfg.hact)))
        else $error("column beyond active width");

endmodule

// File: tb/tb_lcd_sync_gen.sv
`timescale 1ns/1ps
module tb_lcd_sync_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_stn = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [9:0]  wr_data = '0;
    logic        hsync_o, vsync_o, de_o;
    logic [11:0] pix_x_o, line_y_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // field values: index = address (0 vfp,1 vbp,2 vpw,3 vdly,4 hfp,5 hbp,6 hpw,7 hact,8 vact)
    int c[9];

    // measured frame
    int m_f, m_vh, m_gr, m_gf, m_hs, m_de, m_def, m_del, m_bad;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_sync_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_stn(mode_stn),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pix_x_o(pix_x_o), .line_y_o(line_y_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 10'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_all();
        for (int a = 0; a < 9; a++) wr(a, c[a]);
    endtask

    task automatic wait_rise();
        logic pv;
        pv = vsync_o;
        forever begin
            @(negedge clk);
            if (vsync_o && !pv) break;
            pv = vsync_o;
        end
    endtask

    // Called at the sample where vsync has just risen; ends at the next rise.
    task automatic measure(input int ht, input int xa, input int ya);
        logic pv, ph;
        int fall;
        m_vh = 0; m_gr = -1; m_gf = -1; m_hs = 0; m_de = 0;
        m_def = -1; m_del = -1; m_bad = 0; m_f = -1; fall = -1;
        pv = 1'b0; ph = 1'b0;
        for (int idx = 0; idx < 20000; idx++) begin
            if (idx > 0 && vsync_o && !pv) begin m_f = idx; break; end
            if (vsync_o) m_vh++;
            if (hsync_o) m_hs++;
            if (idx > 0 && hsync_o && !ph && m_gr < 0) m_gr = idx;
            if (!vsync_o && pv && fall < 0) fall = idx;
            if (fall >= 0 && m_gf < 0 && hsync_o && !ph && idx > fall) m_gf = idx - fall;
            if (de_o) begin
                m_de++;
                if (m_def < 0) m_def = idx;
                m_del = idx;
                if (int'(pix_x_o) != (idx % ht) - xa || int'(line_y_o) != (idx / ht) - ya)
                    m_bad++;
            end
            pv = vsync_o; ph = hsync_o;
            @(negedge clk);
        end
    endtask

    task automatic verify(input logic stn, input string tag);
        int vpw, vbp, vfp, vdly, ht, vt, xa, ya;
        vpw  = stn ? 0 : c[2];
        vbp  = stn ? 0 : c[1];
        vfp  = stn ? 0 : c[0];
        vdly = stn ? 0 : c[3];
        ht = c[6] + 1 + c[5] + c[7] + c[4];
        vt = vpw + 1 + vbp + c[8] + vfp;
        xa = c[6] + 1 + c[5];
        ya = vpw + 1 + vbp;
        measure(ht, xa, ya);
        chk({tag, " R4 frame cycles"}, m_f, vt * ht);
        chk({tag, " R3 vsync cycles"}, m_vh, (vpw + 1) * ht);
        chk({tag, " R5 gap after vsync rise"}, m_gr, vdly + 1);
        chk({tag, " R5 gap after vsync fall"}, m_gf, vdly + 1);
        chk({tag, " R2 hsync cycles per frame"}, m_hs, vt * (c[6] + 1));
        chk({tag, " R6 enabled pixels"}, m_de, c[7] * c[8]);
        chk({tag, " R4 first enabled index"}, m_def, ya * ht + xa);
        chk({tag, " R4 last enabled index"}, m_del, (ya + c[8] - 1) * ht + xa + c[7] - 1);
        chk({tag, " R6 coordinate mismatches"}, m_bad, 0);
        if (stn) chk({tag, " R7 lines per frame"}, m_f / ht, 1 + c[8]);
    endtask

    task automatic rand_cfg();
        int ht;
        c[6] = $urandom_range(0, 3); c[5] = $urandom_range(0, 3);
        c[7] = $urandom_range(1, 8); c[4] = $urandom_range(0, 3);
        c[2] = $urandom_range(0, 2); c[1] = $urandom_range(0, 2);
        c[8] = $urandom_range(1, 4); c[0] = $urandom_range(0, 2);
        ht = c[6] + 1 + c[5] + c[7] + c[4];
        c[3] = $urandom_range(0, ht - c[6] - 2);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 hsync in reset", int'(hsync_o), 0);
        chk("R1 de in reset", int'(de_o), 0);
        chk("R1 column in reset", int'(pix_x_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 hsync after reset", int'(hsync_o), 0);
        chk("R1 de after reset", int'(de_o), 0);
        chk("R1 row after reset", int'(line_y_o), 0);

        // all-zero porches, pulses and delay
        c = '{0, 0, 0, 0, 0, 0, 0, 4, 3};
        program_all();
        wait_rise();
        verify(1'b0, "zero");

        // directed: large delay, wide pulses; stray writes must be ignored (R9)
        c = '{2, 1, 2, 5, 1, 2, 2, 6, 2};
        program_all();
        wr(9, 1023);
        wr(15, 7);
        wait_rise();
        verify(1'b0, "directed R9");

        // R8: mid-frame write keeps current frame
        wait_rise();
        fork
            verify(1'b0, "R8 old frame");
            wr(7, 3);
        join
        c[7] = 3;
        verify(1'b0, "R8 new frame");

        // R7: passive-matrix mode ignores vertical fields
        c = '{2, 2, 2, 3, 1, 1, 1, 5, 2};
        mode_stn = 1'b1;
        program_all();
        wait_rise();
        verify(1'b1, "R7 stn");
        mode_stn = 1'b0;

        // random settings
        for (int k = 0; k < 6; k++) begin
            rand_cfg();
            program_all();
            wait_rise();
            verify(1'b0, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule